// File: doc/BRIEF.md
# Interrupt Pin Trigger Service Logic

This block tracks interrupt requests on a set of input pins for a programmable interrupt router. It is a per-pin state machine with a shared output arbiter. Each pin has a configuration entry: polarity, trigger mode, mask, vector and destination. Each pin's sampled level is first corrected for polarity. The corrected level then keeps a pending bit for that pin. A pin that is pending and not masked is handed to a single delivery port. The port uses a valid/ready handshake and carries the entry's vector, destination and pin index. Turning the destination into actual targets is left to the logic downstream.

Edge-mode pins deliver once for each rising edge of their corrected level. Level-mode pins deliver while their level is active. After a delivery, a level-mode pin is blocked by a remote-IRR bit. That bit is cleared by an end-of-interrupt whose vector matches the pin's entry; the lowest-numbered entry with that vector is the one cleared. It is also cleared by a strobe that reports that software rewrote the pin's entry. When several pins need service at once they are taken in ascending pin order. The pin inputs are expected to be synchronous to the block clock. The reset input is asserted asynchronously and released through a two-stage synchronizer.

Top module: `irq_pin_service`

## Requirements
- R1: While `rst_n` is low, `dlv_valid` is low. Reset also clears every pending and remote-IRR bit, so a level pin that is active after reset release is delivered again, and appears on `dlv_valid` four clock edges after the release.
- R2: The effective level of pin i is `pin_in[i] ^ cfg_pol[i]`. A pin with `cfg_pol[i]=1` is active while its input is low.
- R3: With `cfg_lvl[i]=0` (edge mode), each 0-to-1 change of the effective level produces one delivery. It appears on `dlv_valid` two clock edges after the changed input is sampled. Holding the level active produces no further delivery.
- R4: A masked edge-mode pin (`cfg_mask[i]=1`) discards its request without delivery, and unmasking it later produces no delivery. A masked pin is never selected for delivery.
- R5: With `cfg_lvl[i]=1` (level mode), a pin whose effective level is active, that is unmasked and whose remote-IRR is clear is delivered. The delivery sets remote-IRR, which blocks further deliveries while the level stays active.
- R6: A masked level-mode pin keeps its request. Clearing the mask while the level is still active delivers it on the next clock edge.
- R7: When `eoi_valid` is high, remote-IRR is cleared for the lowest-numbered entry whose vector equals `eoi_vec`, and only for that entry. If that pin is still active and unmasked, it is delivered again. A higher-numbered entry with the same vector stays blocked.
- R8: An end-of-interrupt whose vector matches no entry changes nothing.
- R9: A cycle with `ent_wr` high clears the remote-IRR of pin `ent_wr_idx`. An active, unmasked level pin is then delivered again.
- R10: Pins that need service are delivered in ascending pin order, one per handshake. A delivery is accepted on a clock edge with `dlv_valid` and `dlv_ready` both high. While `dlv_valid` is high and `dlv_ready` is low, `dlv_pin`, `dlv_vec` and `dlv_dest` hold steady.
- R11: An inactive effective level clears the pin's pending bit, so a request withdrawn before it is selected is never delivered. This holds for a level pin that goes low, and for an edge pin that falls while the output is stalled.
- R12: A delivery of pin i carries `cfg_vec[i*VEC_W +: VEC_W]` on `dlv_vec`, `cfg_dest[i*DEST_W +: DEST_W]` on `dlv_dest`, and i on `dlv_pin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_in | input | NPINS | Raw interrupt pin levels, synchronous to clk |
| cfg_pol | input | NPINS | Per-pin polarity; 1 inverts the pin |
| cfg_lvl | input | NPINS | Per-pin trigger mode; 1 level, 0 edge |
| cfg_mask | input | NPINS | Per-pin mask; 1 blocks delivery |
| cfg_vec | input | NPINS*VEC_W | Per-pin vector fields, pin i at bits i*VEC_W upward |
| cfg_dest | input | NPINS*DEST_W | Per-pin destination fields, pin i at bits i*DEST_W upward |
| ent_wr | input | 1 | Strobe: entry `ent_wr_idx` was rewritten |
| ent_wr_idx | input | $clog2(NPINS) | Index of the rewritten entry |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vec | input | VEC_W | Vector carried by the end-of-interrupt |
| dlv_valid | output | 1 | Delivery request present |
| dlv_ready | input | 1 | Downstream accepts the delivery |
| dlv_vec | output | VEC_W | Vector of the delivered entry |
| dlv_dest | output | DEST_W | Destination of the delivered entry |
| dlv_pin | output | $clog2(NPINS) | Index of the delivered pin |

## Verification
The hardest case to reach from the ports is two entries sharing a vector while both are blocked by remote-IRR. Only then does the lowest-index choice of the end-of-interrupt matcher become visible. The bench reaches it by giving two level pins the same vector and delivering both. Then it sends one end-of-interrupt and checks that only the lower pin comes back while the higher one stays silent. A second case is an edge request that is withdrawn behind a stalled output. The bench holds `dlv_ready` low so that one pin occupies the output, drops a second pin's input, and checks that nothing follows once the stall is released.

// File: rtl/irq_svc_pkg.sv
package irq_svc_pkg;

  localparam int DEF_PINS   = 8;
  localparam int DEF_VEC_W  = 8;
  localparam int DEF_DEST_W = 8;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;

endpackage

// File: rtl/irq_pin_cell.sv
module irq_pin_cell
  import irq_svc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_in,
  input  logic pol,
  input  logic trig_lvl,
  input  logic mask,
  input  logic rirr_clr,
  input  logic issue,
  output logic need,
  output logic pend_o,
  output logic rirr_o
);

  logic eff, eff_q, rise;
  logic pend_q, pend_n;
  logic rirr_q, rirr_n;
  trig_e mode;

  assign mode = trig_e'(trig_lvl);
  assign eff  = lvl_in ^ pol;
  assign rise = eff & ~eff_q;

  always_comb begin
    pend_n = pend_q;
    if (mode == TRIG_LEVEL) begin
      pend_n = eff;
    end else if (!eff) begin
      pend_n = 1'b0;
    end else if (rise) begin
      pend_n = 1'b1;
    end else if (issue || (mask && pend_q)) begin
      pend_n = 1'b0;
    end

    rirr_n = rirr_q;
    if (rirr_clr) rirr_n = 1'b0;
    if (issue && mode == TRIG_LEVEL) rirr_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_q  <= 1'b0;
      pend_q <= 1'b0;
      rirr_q <= 1'b0;
    end else begin
      eff_q  <= eff;
      pend_q <= pend_n;
      rirr_q <= rirr_n;
    end
  end

  assign need   = pend_q & ~mask & ((mode == TRIG_EDGE) | ~rirr_q);
  assign pend_o = pend_q;
  assign rirr_o = rirr_q;

endmodule

// File: rtl/irq_eoi_match.sv
module irq_eoi_match #(
  parameter int NPINS = 8,
  parameter int VEC_W = 8
) (
  input  logic                   eoi_valid,
  input  logic [VEC_W-1:0]       eoi_vec,
  input  logic [NPINS*VEC_W-1:0] cfg_vec,
  output logic [NPINS-1:0]       clr
);

  logic [NPINS-1:0] hit;

  for (genvar g = 0; g < NPINS; g++) begin : g_cmp
    assign hit[g] = eoi_valid && (cfg_vec[g*VEC_W +: VEC_W] == eoi_vec);
  end

  assign clr = hit & (~hit + NPINS'(1));

endmodule

// File: rtl/irq_svc_arb.sv
module irq_svc_arb #(
  parameter int NPINS  = 8,
  parameter int VEC_W  = 8,
  parameter int DEST_W = 8,
  localparam int PIN_W = $clog2(NPINS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPINS-1:0]        need,
  input  logic [NPINS*VEC_W-1:0]  cfg_vec,
  input  logic [NPINS*DEST_W-1:0] cfg_dest,
  output logic [NPINS-1:0]        issue,
  output logic                    dlv_valid,
  input  logic                    dlv_ready,
  output logic [VEC_W-1:0]        dlv_vec,
  output logic [DEST_W-1:0]       dlv_dest,
  output logic [PIN_W-1:0]        dlv_pin
);

  logic             valid_q, valid_n;
  logic             load_en, data_en;
  logic [PIN_W-1:0] sel_idx;
  logic [NPINS-1:0] sel_oh;
  logic [VEC_W-1:0] vec_q;
  logic [DEST_W-1:0] dest_q;
  logic [PIN_W-1:0] pin_q;

  assign sel_oh = need & (~need + NPINS'(1));

  always_comb begin
    sel_idx = '0;
    for (int i = NPINS - 1; i >= 0; i--) begin
      if (need[i]) sel_idx = PIN_W'(i);
    end
  end

  assign load_en = ~valid_q | dlv_ready;
  assign data_en = load_en & (|need);
  assign issue   = load_en ? sel_oh : '0;
  assign valid_n = load_en ? (|need) : valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
      dest_q  <= '0;
      pin_q   <= '0;
    end else begin
      valid_q <= valid_n;
      if (data_en) begin
        vec_q  <= cfg_vec[sel_idx*VEC_W +: VEC_W];
        dest_q <= cfg_dest[sel_idx*DEST_W +: DEST_W];
        pin_q  <= sel_idx;
      end
    end
  end

  assign dlv_valid = valid_q;
  assign dlv_vec   = vec_q;
  assign dlv_dest  = dest_q;
  assign dlv_pin   = pin_q;

endmodule

// File: rtl/irq_pin_service.sv
module irq_pin_service
  import irq_svc_pkg::*;
#(
  parameter int NPINS  = DEF_PINS,
  parameter int VEC_W  = DEF_VEC_W,
  parameter int DEST_W = DEF_DEST_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPINS-1:0]           pin_in,
  input  logic [NPINS-1:0]           cfg_pol,
  input  logic [NPINS-1:0]           cfg_lvl,
  input  logic [NPINS-1:0]           cfg_mask,
  input  logic [NPINS*VEC_W-1:0]     cfg_vec,
  input  logic [NPINS*DEST_W-1:0]    cfg_dest,
  input  logic                       ent_wr,
  input  logic [$clog2(NPINS)-1:0]   ent_wr_idx,
  input  logic                       eoi_valid,
  input  logic [VEC_W-1:0]           eoi_vec,
  output logic                       dlv_valid,
  input  logic                       dlv_ready,
  output logic [VEC_W-1:0]           dlv_vec,
  output logic [DEST_W-1:0]          dlv_dest,
  output logic [$clog2(NPINS)-1:0]   dlv_pin
);

  logic             rst_s1, rst_s;
  logic [NPINS-1:0] need, issue, pend, rirr, eoi_clr, wr_clr, rirr_clr;

  // reset: asserted asynchronously, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s  <= rst_s1;
    end
  end

  irq_eoi_match #(.NPINS(NPINS), .VEC_W(VEC_W)) u_eoi (
    .eoi_valid (eoi_valid),
    .eoi_vec   (eoi_vec),
    .cfg_vec   (cfg_vec),
    .clr       (eoi_clr)
  );

  assign wr_clr   = ent_wr ? ({{(NPINS-1){1'b0}}, 1'b1} << ent_wr_idx) : '0;
  assign rirr_clr = eoi_clr | wr_clr;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    irq_pin_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_s),
      .lvl_in   (pin_in[g]),
      .pol      (cfg_pol[g]),
      .trig_lvl (cfg_lvl[g]),
      .mask     (cfg_mask[g]),
      .rirr_clr (rirr_clr[g]),
      .issue    (issue[g]),
      .need     (need[g]),
      .pend_o   (pend[g]),
      .rirr_o   (rirr[g])
    );
  end

  irq_svc_arb #(.NPINS(NPINS), .VEC_W(VEC_W), .DEST_W(DEST_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_s),
    .need      (need),
    .cfg_vec   (cfg_vec),
    .cfg_dest  (cfg_dest),
    .issue     (issue),
    .dlv_valid (dlv_valid),
    .dlv_ready (dlv_ready),
    .dlv_vec   (dlv_vec),
    .dlv_dest  (dlv_dest),
    .dlv_pin   (dlv_pin)
  );

endmodule

// File: rtl/irq_pin_service_chk.sv
module irq_pin_service_chk #(
  parameter int NPINS  = 8,
  parameter int VEC_W  = 8,
  parameter int DEST_W = 8
) (
  input logic                     clk,
  input logic                     rst_s,
  input logic                     dlv_valid,
  input logic                     dlv_ready,
  input logic [VEC_W-1:0]         dlv_vec,
  input logic [DEST_W-1:0]        dlv_dest,
  input logic [$clog2(NPINS)-1:0] dlv_pin,
  input logic [NPINS-1:0]         issue,
  input logic [NPINS-1:0]         pend,
  input logic [NPINS-1:0]         rirr,
  input logic [NPINS-1:0]         cfg_mask,
  input logic [NPINS-1:0]         cfg_lvl,
  input logic                     eoi_valid,
  input logic [NPINS-1:0]         eoi_clr
);

  p_edge_clear_r3: assert property (@(posedge clk) disable iff (!rst_s)
    (|(issue & ~cfg_lvl)) |=> ((pend & $past(issue & ~cfg_lvl)) == '0));

  p_no_masked_issue_r4: assert property (@(posedge clk) disable iff (!rst_s)
    ((issue & cfg_mask) == '0));

  p_level_gate_r5: assert property (@(posedge clk) disable iff (!rst_s)
    ((issue & cfg_lvl & rirr) == '0));

  p_eoi_single_r7: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(eoi_clr));

  p_eoi_idle_r8: assert property (@(posedge clk) disable iff (!rst_s)
    !eoi_valid |-> (eoi_clr == '0));

  p_issue_onehot_r10: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(issue));

  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_s)
    (dlv_valid && !dlv_ready) |=>
      (dlv_valid && $stable(dlv_vec) && $stable(dlv_dest) && $stable(dlv_pin)));

  p_issue_presents_r12: assert property (@(posedge clk) disable iff (!rst_s)
    (|issue) |=> dlv_valid);

endmodule

bind irq_pin_service irq_pin_service_chk #(
  .NPINS(NPINS), .VEC_W(VEC_W), .DEST_W(DEST_W)
) u_chk (
  .clk       (clk),
  .rst_s     (rst_s),
  .dlv_valid (dlv_valid),
  .dlv_ready (dlv_ready),
  .dlv_vec   (dlv_vec),
  .dlv_dest  (dlv_dest),
  .dlv_pin   (dlv_pin),
  .issue     (issue),
  .pend      (pend),
  .rirr      (rirr),
  .cfg_mask  (cfg_mask),
  .cfg_lvl   (cfg_lvl),
  .eoi_valid (eoi_valid),
  .eoi_clr   (eoi_clr)
);

// File: tb/irq_pin_service_test.sv
`timescale 1ns/1ps
module irq_pin_service_test;

  localparam int NP = 8;
  localparam int VW = 8;
  localparam int DW = 8;
  localparam logic [7:0] IDLE = 8'h0A;  // pins 1 and 3 have polarity 1

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] pin_in, cfg_pol, cfg_lvl, cfg_mask;
  logic [NP*VW-1:0] cfg_vec;
  logic [NP*DW-1:0] cfg_dest;
  logic          ent_wr;
  logic [2:0]    ent_wr_idx;
  logic          eoi_valid;
  logic [VW-1:0] eoi_vec;
  logic          dlv_valid, dlv_ready;
  logic [VW-1:0] dlv_vec;
  logic [DW-1:0] dlv_dest;
  logic [2:0]    dlv_pin;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_pin_service #(.NPINS(NP), .VEC_W(VW), .DEST_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cfg_pol(cfg_pol),
    .cfg_lvl(cfg_lvl), .cfg_mask(cfg_mask), .cfg_vec(cfg_vec),
    .cfg_dest(cfg_dest), .ent_wr(ent_wr), .ent_wr_idx(ent_wr_idx),
    .eoi_valid(eoi_valid), .eoi_vec(eoi_vec), .dlv_valid(dlv_valid),
    .dlv_ready(dlv_ready), .dlv_vec(dlv_vec), .dlv_dest(dlv_dest),
    .dlv_pin(dlv_pin)
  );

  // row: {pins[8], ready, eoi_v, eoi_vec[8], exp_valid, exp_pin[3]}
  localparam logic [21:0] TBL [24] = '{
    {8'h0A, 1'b1, 1'b0, 8'h00, 1'b0, 3'd0},  // 0  idle
    {8'h0B, 1'b1, 1'b0, 8'h00, 1'b0, 3'd0},  // 1  pin0 rises, pending only
    {8'h0B, 1'b1, 1'b0, 8'h00, 1'b1, 3'd0},  // 2  R3 pin0 delivered
    {8'h0B, 1'b1, 1'b0, 8'h00, 1'b0, 3'd0},  // 3  R3 held high, no repeat
    {8'h08, 1'b1, 1'b0, 8'h00, 1'b0, 3'd0},  // 4  pin1 low = active
    {8'h08, 1'b1, 1'b0, 8'h00, 1'b1, 3'd1},  // 5  R2 inverted pin delivered
    {8'h0A, 1'b1, 1'b0, 8'h00, 1'b0, 3'd0},  // 6
    {8'h0E, 1'b1, 1'b0, 8'h00, 1'b0, 3'd0},  // 7  level pin2 active
    {8'h0E, 1'b1, 1'b0, 8'h00, 1'b1, 3'd2},  // 8  R5 delivered
    {8'h0E, 1'b1, 1'b0, 8'h00, 1'b0, 3'd0},  // 9  R5 blocked
    {8'h0E, 1'b1, 1'b0, 8'h00, 1'b0, 3'd0},  // 10 R5 blocked
    {8'h0E, 1'b1, 1'b1, 8'h99, 1'b0, 3'd0},  // 11 R8 unmatched eoi
    {8'h0E, 1'b1, 1'b0, 8'h00, 1'b0, 3'd0},  // 12 R8 still blocked
    {8'h0E, 1'b1, 1'b1, 8'h22, 1'b0, 3'd0},  // 13 R7 eoi for pin2
    {8'h0E, 1'b1, 1'b0, 8'h00, 1'b1, 3'd2},  // 14 R7 redelivered
    {8'h0A, 1'b1, 1'b0, 8'h00, 1'b0, 3'd0},  // 15 pin2 inactive
    {8'h0A, 1'b1, 1'b1, 8'h22, 1'b0, 3'd0},  // 16 eoi while inactive
    {8'h0A, 1'b1, 1'b0, 8'h00, 1'b0, 3'd0},  // 17 R11 no delivery
    {8'h1B, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0},  // 18 pins 0 and 4 rise
    {8'h1B, 1'b0, 1'b0, 8'h00, 1'b1, 3'd0},  // 19 R10 lowest first
    {8'h1B, 1'b0, 1'b0, 8'h00, 1'b1, 3'd0},  // 20 R10 held while stalled
    {8'h1B, 1'b1, 1'b0, 8'h00, 1'b1, 3'd4},  // 21 R10 next pin
    {8'h1B, 1'b1, 1'b0, 8'h00, 1'b0, 3'd0},  // 22
    {8'h0A, 1'b1, 1'b0, 8'h00, 1'b0, 3'd0}   // 23
  };

  function automatic logic [7:0] exp_vec(input int p);
    return (p == 7) ? 8'h26 : 8'(8'h20 + p);
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // R12: payload is checked on every expected delivery
  task automatic check(input bit ev, input int ep, input string tag);
    n_chk++;
    if (dlv_valid !== ev) begin
      n_fail++;
      $display("FAIL %s: dlv_valid=%0b expected %0b", tag, dlv_valid, ev);
    end else if (ev && (dlv_pin !== 3'(ep) || dlv_vec !== exp_vec(ep) ||
                        dlv_dest !== 8'(8'h40 + ep))) begin
      n_fail++;
      $display("FAIL %s (R12): pin/vec/dest=%0d/%h/%h expected %0d/%h/%h",
               tag, dlv_pin, dlv_vec, dlv_dest, ep, exp_vec(ep), 8'(8'h40 + ep));
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: cycles=%0d expected < 20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    pin_in = IDLE;
    cfg_pol = 8'h0A;
    cfg_lvl = 8'hCC;
    cfg_mask = 8'h60;
    for (int i = 0; i < NP; i++) begin
      cfg_vec[i*VW +: VW] = exp_vec(i);
      cfg_dest[i*DW +: DW] = 8'(8'h40 + i);
    end
    ent_wr = 1'b0;
    ent_wr_idx = '0;
    eoi_valid = 1'b0;
    eoi_vec = '0;
    dlv_ready = 1'b1;
    repeat (3) tick();
    check(0, 0, "R1 in reset");
    rst_n = 1'b1;
    repeat (3) tick();
    check(0, 0, "R1 after release");

    for (int r = 0; r < 24; r++) begin
      pin_in    = TBL[r][21:14];
      dlv_ready = TBL[r][13];
      eoi_valid = TBL[r][12];
      eoi_vec   = TBL[r][11:4];
      tick();
      check(TBL[r][3], int'(TBL[r][2:0]), $sformatf("table row %0d", r));
    end
    eoi_valid = 1'b0;

    // R4: masked edge pin 5 drops its request
    pin_in = IDLE | 8'h20;
    tick(); tick();
    cfg_mask[5] = 1'b0;
    tick();
    check(0, 0, "R4 masked edge discarded");
    tick();
    check(0, 0, "R4 no delivery after unmask");
    pin_in = IDLE;
    tick();

    // R6: masked level pin 6 waits for unmask
    pin_in = IDLE | 8'h40;
    tick(); tick();
    check(0, 0, "R6 masked level held");
    cfg_mask[6] = 1'b0;
    tick();
    check(1, 6, "R6 delivered on unmask");
    tick();
    check(0, 0, "R5 pin6 blocked");

    // R9: entry rewrite clears remote-IRR
    ent_wr = 1'b1;
    ent_wr_idx = 3'd6;
    tick();
    check(0, 0, "R9 strobe cycle");
    ent_wr = 1'b0;
    tick();
    check(1, 6, "R9 redelivered after rewrite");
    tick();

    // R7: pins 6 and 7 share vector 0x26; eoi picks pin 6
    pin_in = IDLE | 8'hC0;
    tick(); tick();
    check(1, 7, "R7 pin7 delivered");
    tick();
    check(0, 0, "R7 both blocked");
    eoi_valid = 1'b1;
    eoi_vec = 8'h26;
    tick();
    eoi_valid = 1'b0;
    tick();
    check(1, 6, "R7 lowest matching entry redelivered");
    tick();
    check(0, 0, "R7 higher duplicate stays blocked");
    tick();
    check(0, 0, "R7 higher duplicate still blocked");

    // R1: reset mid-run clears remote-IRR
    rst_n = 1'b0;
    #1;
    check(0, 0, "R1 async assert");
    tick();
    rst_n = 1'b1;
    repeat (4) tick();
    check(1, 6, "R1 redelivery after reset release");
    pin_in = IDLE;
    repeat (4) tick();

    // R11: edge pin withdrawn while output stalled
    dlv_ready = 1'b0;
    pin_in = IDLE | 8'h11;
    tick(); tick();
    check(1, 0, "R11 pin0 holds output");
    pin_in = IDLE | 8'h01;
    tick();
    check(1, 0, "R10 still held");
    dlv_ready = 1'b1;
    tick();
    check(0, 0, "R11 withdrawn edge request lost");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule